// File: doc/BRIEF.md
# Stack Board Command and Register Decoder

This block sits on the serial command path of one board in a daisy-chained stack of waveform boards. Every board in the chain sees the same command byte stream. Each board keeps only the commands aimed at its own strap-set identity or at the shared broadcast identity. The block holds three small control registers: a configuration byte, a checksum byte and a frame selector. It answers register reads and turns the configuration byte into the board-level control lines.

A command byte comes first. For a register write, one data byte follows and is stored. A register read is answered on the cycle after the command, and only when the command names this board by its own number. Memory commands are only flagged for the memory write path; their data bytes never reach the registers here. The configuration byte also drives the trigger and AUX outputs. The trigger merges a software bit with the hardware pin. The AUX pin shows either the SPI MISO line or a masked OR of the per-channel aux flags.

Top module: `stack_reg_decoder`

## Requirements
- R1: After reset, all outputs are 0: sys_reset_o, clk2x_o, run_en_o, trigger_o, aux_o, frame_o, rd_valid_o, rd_data_o, mem_route_o and mem_id_o.
- R2: A command byte is decoded as write flag = bit 7, board number = bits 6:3, memory flag = bit 2, selector = bits 1:0. It is accepted only when the board number equals board_id or equals 15 (broadcast). Any other command changes no register.
- R3: A register write takes effect at the clock edge that samples data_valid. The data byte must follow an accepted write command whose memory flag is clear and whose selector is 0 (configuration). In the following cycle, clk2x_o shows data bit 1 and run_en_o shows data bit 2.
- R4: Configuration bit 0 is a reset request. Writing it as 1 raises sys_reset_o for exactly one cycle. The bit then clears itself and reads back as 0, and the other configuration bits are kept.
- R5: trigger_o is registered, one cycle after its inputs. It equals the hardware trigger pin ORed with configuration bit 3.
- R6: aux_o is registered, one cycle after its inputs. When configuration bit 4 is set, it equals spi_miso. Otherwise it is 1 when any chan_aux bit is set under the mask in configuration bits 7:5 (mask bit i goes with chan_aux bit i).
- R7: Selector 1 with the memory flag clear addresses the 8-bit checksum register, which can be written and read back.
- R8: Selector 2 with the memory flag clear addresses the frame register. It keeps the low FRAME_W bits of the data byte, shows them on frame_o, and reads back zero-extended.
- R9: A read command (write flag 0, memory flag 0) whose board number equals board_id, and is not 15, raises rd_valid_o in the next cycle with the register value on rd_data_o. Selector 3 reads 0. A broadcast read or a read for another board leaves rd_valid_o low, and rd_data_o is 0 whenever rd_valid_o is low.
- R10: An accepted command with the memory flag set raises mem_route_o from the next cycle, with its selector on mem_id_o. Its data bytes change no register. The next accepted register command clears mem_route_o.
- R11: One write command consumes exactly one data byte. A data byte with no pending register write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte | input | 8 | Command byte |
| cmd_valid | input | 1 | cmd_byte is present this cycle |
| data_byte | input | 8 | Data byte following a write command |
| data_valid | input | 1 | data_byte is present this cycle |
| board_id | input | 4 | Strap-set number of this board |
| trig_pin | input | 1 | Hardware trigger input |
| spi_miso | input | 1 | SPI MISO line, routable to AUX |
| chan_aux | input | MASK_W | Per-channel aux flags |
| sys_reset_o | output | 1 | One-cycle board logic reset pulse |
| clk2x_o | output | 1 | Clock doubler enable |
| run_en_o | output | 1 | Waveform execution enable |
| trigger_o | output | 1 | Combined trigger |
| frame_o | output | FRAME_W | Selected frame |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 8 | Read response data |
| mem_route_o | output | 1 | Last accepted command targets a memory |
| mem_id_o | output | 2 | Memory index of that command |
| aux_o | output | 1 | AUX pin |

## Verification
Commands are sent with the board number equal to the strap, with broadcast 15, and with a foreign number. The same write and read traffic under each shows whether the identity match, the broadcast acceptance and the rule against answering broadcast reads are told apart. The AUX pin is tried with mask-covered and mask-excluded channel flags, and then in MISO mode with both MISO levels, which separates the mask logic from the source select. Memory commands, orphan data bytes and an unused selector are sent between known register contents, so that a stray register write shows up on frame_o or on a read-back.

// File: rtl/stack_reg_pkg.sv
package stack_reg_pkg;
  localparam logic [3:0] BCAST_ID = 4'hF;
  localparam int MASK_W = 3;

  // field positions inside the configuration byte
  localparam int CFG_RST  = 0;
  localparam int CFG_X2   = 1;
  localparam int CFG_RUN  = 2;
  localparam int CFG_TRG  = 3;
  localparam int CFG_MISO = 4;
  localparam int CFG_MSK  = 5;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_SUM  = 2'd1,
    SEL_FRM  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // packed in the same bit order as the command byte
  typedef struct packed {
    logic       wr;
    logic [3:0] board;
    logic       is_mem;
    logic [1:0] sel;
  } cmd_t;
endpackage

// File: rtl/stack_cmd_decode.sv
module stack_cmd_decode
  import stack_reg_pkg::*;
(
  input  logic [7:0] cmd_byte,
  input  logic [3:0] board_id,
  output logic       wr,
  output logic       is_mem,
  output logic [1:0] sel,
  output logic       hit,
  output logic       exact
);
  cmd_t c;

  always_comb begin
    c      = cmd_t'(cmd_byte);
    wr     = c.wr;
    is_mem = c.is_mem;
    sel    = c.sel;
    hit    = (c.board == board_id) || (c.board == BCAST_ID);
    exact  = (c.board == board_id) && (c.board != BCAST_ID);
  end
endmodule

// File: rtl/stack_reg_bank.sv
module stack_reg_bank
  import stack_reg_pkg::*;
#(
  parameter int FRAME_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic               wr,
  input  logic               is_mem,
  input  logic [1:0]         sel,
  input  logic               hit,
  input  logic               exact,
  input  logic               data_valid,
  input  logic [7:0]         data_byte,
  output logic [7:0]         cfg_q,
  output logic [7:0]         sum_q,
  output logic [FRAME_W-1:0] frame_q,
  output logic               rd_valid_q,
  output logic [7:0]         rd_data_q,
  output logic               mem_route_q,
  output logic [1:0]         mem_id_q
);
  logic       wr_pend;
  logic [1:0] wr_sel;
  logic [7:0] frm_ext;
  logic [7:0] rd_val;

  always_comb begin
    frm_ext = '0;
    frm_ext[FRAME_W-1:0] = frame_q;
    case (reg_sel_e'(sel))
      SEL_CFG: rd_val = {cfg_q[7:1], 1'b0};
      SEL_SUM: rd_val = sum_q;
      SEL_FRM: rd_val = frm_ext;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      sum_q       <= '0;
      frame_q     <= '0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
      mem_route_q <= 1'b0;
      mem_id_q    <= '0;
      wr_pend     <= 1'b0;
      wr_sel      <= '0;
    end else begin
      cfg_q[CFG_RST] <= 1'b0;
      rd_valid_q     <= 1'b0;
      rd_data_q      <= '0;
      if (cmd_valid) begin
        wr_pend     <= hit & wr & ~is_mem;
        wr_sel      <= sel;
        mem_route_q <= hit & is_mem;
        if (hit & is_mem) mem_id_q <= sel;
        if (exact & ~wr & ~is_mem) begin
          rd_valid_q <= 1'b1;
          rd_data_q  <= rd_val;
        end
      end else if (data_valid && wr_pend) begin
        wr_pend <= 1'b0;
        case (reg_sel_e'(wr_sel))
          SEL_CFG: cfg_q   <= data_byte;
          SEL_SUM: sum_q   <= data_byte;
          SEL_FRM: frame_q <= data_byte[FRAME_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stack_pin_stage.sv
module stack_pin_stage #(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_trig,
  input  logic              trig_pin,
  input  logic              miso_sel,
  input  logic [MASK_W-1:0] aux_mask,
  input  logic [MASK_W-1:0] chan_aux,
  input  logic              spi_miso,
  output logic              trigger_q,
  output logic              aux_q
);
  logic masked_any;

  always_comb masked_any = |(aux_mask & chan_aux);

  always_ff @(posedge clk) begin
    if (rst) begin
      trigger_q <= 1'b0;
      aux_q     <= 1'b0;
    end else begin
      trigger_q <= soft_trig | trig_pin;
      aux_q     <= miso_sel ? spi_miso : masked_any;
    end
  end
endmodule

// File: rtl/stack_reg_decoder.sv
module stack_reg_decoder
  import stack_reg_pkg::*;
#(
  parameter int FRAME_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         cmd_byte,
  input  logic               cmd_valid,
  input  logic [7:0]         data_byte,
  input  logic               data_valid,
  input  logic [3:0]         board_id,
  input  logic               trig_pin,
  input  logic               spi_miso,
  input  logic [MASK_W-1:0]  chan_aux,
  output logic               sys_reset_o,
  output logic               clk2x_o,
  output logic               run_en_o,
  output logic               trigger_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               rd_valid_o,
  output logic [7:0]         rd_data_o,
  output logic               mem_route_o,
  output logic [1:0]         mem_id_o,
  output logic               aux_o
);
  logic       d_wr, d_mem, d_hit, d_exact;
  logic [1:0] d_sel;
  logic [7:0] cfg, sum;

  stack_cmd_decode dec_i (
    .cmd_byte (cmd_byte),
    .board_id (board_id),
    .wr       (d_wr),
    .is_mem   (d_mem),
    .sel      (d_sel),
    .hit      (d_hit),
    .exact    (d_exact)
  );

  stack_reg_bank #(.FRAME_W(FRAME_W)) bank_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .wr          (d_wr),
    .is_mem      (d_mem),
    .sel         (d_sel),
    .hit         (d_hit),
    .exact       (d_exact),
    .data_valid  (data_valid),
    .data_byte   (data_byte),
    .cfg_q       (cfg),
    .sum_q       (sum),
    .frame_q     (frame_o),
    .rd_valid_q  (rd_valid_o),
    .rd_data_q   (rd_data_o),
    .mem_route_q (mem_route_o),
    .mem_id_q    (mem_id_o)
  );

  stack_pin_stage #(.MASK_W(MASK_W)) pins_i (
    .clk       (clk),
    .rst       (rst),
    .soft_trig (cfg[CFG_TRG]),
    .trig_pin  (trig_pin),
    .miso_sel  (cfg[CFG_MISO]),
    .aux_mask  (cfg[CFG_MSK +: MASK_W]),
    .chan_aux  (chan_aux),
    .spi_miso  (spi_miso),
    .trigger_q (trigger_o),
    .aux_q     (aux_o)
  );

  // the checksum byte has no control role; it is only read back
  logic unused_sum;
  always_comb unused_sum = ^sum;

  always_comb begin
    sys_reset_o = cfg[CFG_RST];
    clk2x_o     = cfg[CFG_X2];
    run_en_o    = cfg[CFG_RUN];
  end
endmodule

// File: rtl/stack_reg_chk.sv
module stack_reg_chk #(
  parameter int FRAME_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         cmd_byte,
  input logic               cmd_valid,
  input logic               data_valid,
  input logic               trig_pin,
  input logic               sys_reset_o,
  input logic               clk2x_o,
  input logic               run_en_o,
  input logic               trigger_o,
  input logic [FRAME_W-1:0] frame_o,
  input logic               rd_valid_o,
  input logic [7:0]         rd_data_o,
  input logic               mem_route_o
);
  // R4
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_o |=> !sys_reset_o);

  // R5
  trig_pin_chk: assert property (@(posedge clk) disable iff (rst)
    trig_pin |=> trigger_o);

  // R9
  rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(cmd_valid));

  // R9
  rd_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[6:3] == 4'hF) |=> !rd_valid_o);

  // R9
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> (rd_data_o == 8'h00));

  // R11
  no_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !data_valid |=> $stable({clk2x_o, run_en_o, frame_o}));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_route_o && data_valid && !cmd_valid) |=> $stable({clk2x_o, run_en_o, frame_o}));
endmodule

bind stack_reg_decoder stack_reg_chk #(.FRAME_W(FRAME_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cmd_byte    (cmd_byte),
  .cmd_valid   (cmd_valid),
  .data_valid  (data_valid),
  .trig_pin    (trig_pin),
  .sys_reset_o (sys_reset_o),
  .clk2x_o     (clk2x_o),
  .run_en_o    (run_en_o),
  .trigger_o   (trigger_o),
  .frame_o     (frame_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .mem_route_o (mem_route_o)
);

// File: tb/stack_reg_decoder_tb.sv
`timescale 1ns/1ps
module stack_reg_decoder_tb_top;
  localparam int FW = 5;
  localparam logic [3:0] ME = 4'd5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    cmd_byte = '0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    data_byte = '0;
  logic          data_valid = 1'b0;
  logic [3:0]    board_id = ME;
  logic          trig_pin = 1'b0;
  logic          spi_miso = 1'b0;
  logic [2:0]    chan_aux = '0;
  logic          sys_reset_o, clk2x_o, run_en_o, trigger_o;
  logic [FW-1:0] frame_o;
  logic          rd_valid_o;
  logic [7:0]    rd_data_o;
  logic          mem_route_o;
  logic [1:0]    mem_id_o;
  logic          aux_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stack_reg_decoder #(.FRAME_W(FW)) dut_i (
    .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
    .data_byte(data_byte), .data_valid(data_valid), .board_id(board_id),
    .trig_pin(trig_pin), .spi_miso(spi_miso), .chan_aux(chan_aux),
    .sys_reset_o(sys_reset_o), .clk2x_o(clk2x_o), .run_en_o(run_en_o),
    .trigger_o(trigger_o), .frame_o(frame_o), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .mem_route_o(mem_route_o), .mem_id_o(mem_id_o),
    .aux_o(aux_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [3:0] b, input logic m, input logic [1:0] a, input logic w);
    @(negedge clk);
    cmd_byte  = {w, b, m, a};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_data(input logic [7:0] d);
    @(negedge clk);
    data_byte  = d;
    data_valid = 1'b1;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] b, input logic [1:0] a, input logic [7:0] d);
    send_cmd(b, 1'b0, a, 1'b1);
    send_data(d);
  endtask

  task automatic rd_reg(input string req, input logic [3:0] b, input logic [1:0] a,
                        input logic exp_v, input logic [7:0] exp_d);
    send_cmd(b, 1'b0, a, 1'b0);
    check({req, " rd_valid"}, rd_valid_o, exp_v);
    check({req, " rd_data"}, rd_data_o, exp_d);
  endtask

  task automatic t_reset;
    check("R1 outputs", {sys_reset_o, clk2x_o, run_en_o, trigger_o, aux_o,
                         rd_valid_o, mem_route_o, mem_id_o}, '0);
    check("R1 frame", frame_o, '0);
    check("R1 rd_data", rd_data_o, '0);
  endtask

  task automatic t_cfg;
    wr_reg(ME, 2'd0, 8'h06);
    check("R3 clk2x", clk2x_o, 1'b1);
    check("R3 run_en", run_en_o, 1'b1);
    rd_reg("R9 cfg", ME, 2'd0, 1'b1, 8'h06);
  endtask

  task automatic t_boards;
    wr_reg(4'hF, 2'd0, 8'h02);
    check("R2 bcast clk2x", clk2x_o, 1'b1);
    check("R2 bcast run_en", run_en_o, 1'b0);
    rd_reg("R9 bcast", 4'hF, 2'd0, 1'b0, 8'h00);
    wr_reg(4'd3, 2'd0, 8'h04);
    check("R2 foreign clk2x", clk2x_o, 1'b1);
    check("R2 foreign run_en", run_en_o, 1'b0);
    rd_reg("R9 foreign", 4'd3, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic t_selfclear;
    wr_reg(ME, 2'd0, 8'h07);
    check("R4 pulse", sys_reset_o, 1'b1);
    @(negedge clk);
    check("R4 cleared", sys_reset_o, 1'b0);
    check("R4 run_en kept", run_en_o, 1'b1);
    rd_reg("R4 readback", ME, 2'd0, 1'b1, 8'h06);
  endtask

  task automatic t_trigger;
    @(negedge clk); trig_pin = 1'b1;
    @(negedge clk); check("R5 pin high", trigger_o, 1'b1);
    trig_pin = 1'b0;
    @(negedge clk); check("R5 pin low", trigger_o, 1'b0);
    wr_reg(ME, 2'd0, 8'h08);
    @(negedge clk); check("R5 soft", trigger_o, 1'b1);
    wr_reg(ME, 2'd0, 8'h00);
    @(negedge clk); check("R5 soft off", trigger_o, 1'b0);
  endtask

  task automatic t_aux;
    wr_reg(ME, 2'd0, 8'hA0);
    chan_aux = 3'b010;
    idle(2); check("R6 masked out", aux_o, 1'b0);
    chan_aux = 3'b100;
    idle(2); check("R6 masked in", aux_o, 1'b1);
    chan_aux = 3'b000;
    wr_reg(ME, 2'd0, 8'h10);
    spi_miso = 1'b1;
    idle(2); check("R6 miso high", aux_o, 1'b1);
    spi_miso = 1'b0; chan_aux = 3'b111;
    idle(2); check("R6 miso low", aux_o, 1'b0);
    chan_aux = 3'b000;
  endtask

  task automatic t_regs;
    wr_reg(ME, 2'd1, 8'hA5);
    rd_reg("R7 sum", ME, 2'd1, 1'b1, 8'hA5);
    wr_reg(ME, 2'd2, 8'hFF);
    check("R8 frame_o", frame_o, 5'h1F);
    rd_reg("R8 frame read", ME, 2'd2, 1'b1, 8'h1F);
  endtask

  task automatic t_mem;
    send_cmd(ME, 1'b1, 2'd1, 1'b1);
    check("R10 route", mem_route_o, 1'b1);
    check("R10 id", mem_id_o, 2'd1);
    send_data(8'h00);
    check("R10 frame kept", frame_o, 5'h1F);
    rd_reg("R10 sum kept", ME, 2'd1, 1'b1, 8'hA5);
    check("R10 route cleared", mem_route_o, 1'b0);
  endtask

  task automatic t_orphan;
    send_data(8'h03);
    check("R11 orphan frame", frame_o, 5'h1F);
    wr_reg(ME, 2'd2, 8'h04);
    send_data(8'h09);
    check("R11 single byte", frame_o, 5'h04);
    rd_reg("R9 sel3", ME, 2'd3, 1'b1, 8'h00);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset;
    rst = 1'b0;
    idle(1);
    t_cfg;
    t_boards;
    t_selfclear;
    t_trigger;
    t_aux;
    t_regs;
    t_mem;
    t_orphan;
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule